// File: doc/BRIEF.md
# Subword Spare Allocator for a Segmented Memory

This block decides, while a memory self-test is running, which spare resources repair the failures the test reports. Each failing word arrives as one event carrying its row address, its column address and a mask with one bit per subword. A subword is a run of adjacent data bits whose width equals the width of a spare column group. The array is divided into segments by the top bits of the row address. Spare rows replace a whole row. A spare column group replaces one subword position, at one column address, inside one segment.

Allocation is greedy and is done one event at a time. Any failure that an existing spare already covers is dropped. A word with two or more uncovered failing subwords takes a spare row. A single uncovered subword takes a spare row when an earlier column group in the same segment already holds the same column address for another subword position. Otherwise a single uncovered subword takes a column group. A failure that finds no spare of the kind it needs clears the repairable flag, and the flag stays cleared for the rest of the run. The outputs are the spare registers and the flag. They are meant for the repair datapath that follows this block.

The controller has five states. IDLE follows reset. It moves to CLEAR on `start`. CLEAR empties every spare entry and moves to COLLECT. COLLECT moves to JUDGE when an event is accepted and to DONE on `test_end`. JUDGE commits at most one allocation and moves back to COLLECT. DONE holds the results and moves to CLEAR on `start`.

Top module: `subword_repair_alloc`

## Requirements
- R1: After reset, and in the cycle after a `start` taken in IDLE or DONE, every spare row and column group entry is invalid and `repairable` is 1.
- R2: An accepted event whose failing subwords, after column-group coverage is removed, number two or more takes the lowest-index free spare row, which records the event's row address.
- R3: An event produces no allocation in three cases: its row matches a valid spare row, every failing subword matches a valid column group with the same segment, column address and subword index, or its mask is zero.
- R4: A single uncovered failing subword takes the lowest free spare row when a valid column group with the same segment and column address already exists. If no row is free, it takes the lowest free column group instead.
- R5: Any other single uncovered failing subword takes the lowest free column group, which records the segment, the column address and the subword index. Mask bit k is subword index k.
- R6: When an event needs a spare and none of the usable kind is free, `repairable` drops to 0. It stays 0, with no further allocation, until the next `start`.
- R7: The segment is the top log2(N_SEG) bits of the row address. A column group covers failures only in its own segment.
- R8: `ready` is 1 only in COLLECT. An event is accepted when `fail_valid` and `ready` are both 1. Its result is visible by the time `ready` returns to 1, two clock edges later.
- R9: `test_end` in COLLECT moves the block to DONE, where `done` is 1 and `ready` is 0. At most one spare entry becomes valid per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new analysis (honoured in IDLE and DONE) |
| test_end | input | 1 | Self-test finished (honoured in COLLECT) |
| fail_valid | input | 1 | Failing-word event present |
| fail_row | input | ROW_W | Row address of the failing word |
| fail_col | input | COL_W | Column address of the failing word |
| fail_mask | input | WORD_W/GRP_W | One bit per failing subword |
| ready | output | 1 | Block can accept an event |
| done | output | 1 | Analysis finished |
| repairable | output | 1 | All failures so far are covered |
| srow_vld | output | N_SROW | Spare row entry valid bits |
| srow_addr | output | N_SROW*ROW_W | Spare row addresses, entry i at bits i*ROW_W |
| scg_vld | output | N_SCG | Column group entry valid bits |
| scg_seg | output | N_SCG*log2(N_SEG) | Column group segment per entry |
| scg_col | output | N_SCG*COL_W | Column group column address per entry |
| scg_sub | output | N_SCG*log2(WORD_W/GRP_W) | Column group subword index per entry |

## Verification
The assertions assume three things about the inputs. Events are offered only while `ready` is high. `start` and `test_end` arrive only in the states that honour them. Reset is applied before the first event. Under these conditions, spare entries become valid only from JUDGE, one at a time, and lose validity only in CLEAR. The stimulus keeps within these conditions by waiting for `ready` before each event, dropping `fail_valid` one cycle after it is taken, and pulsing `start` and `test_end` only in IDLE, COLLECT or DONE. Two runs are arranged so that each allocation path is reached, and each spare kind is exhausted at least once.

// File: rtl/sra_pkg.sv
package sra_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_COLLECT,
        ST_JUDGE,
        ST_DONE
    } sra_state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_ROW,
        ACT_COL,
        ACT_FAIL
    } sra_act_e;

endpackage

// File: rtl/sra_free_pick.sv
module sra_free_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vld,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/sra_cover_lookup.sv
module sra_cover_lookup #(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 2,
    parameter int SEG_W  = 1,
    parameter int NSW    = 4,
    parameter int SUB_W  = 2,
    parameter int N_SROW = 4,
    parameter int N_SCG  = 2
) (
    input  logic [ROW_W-1:0]        ev_row,
    input  logic [COL_W-1:0]        ev_col,
    input  logic [NSW-1:0]          ev_mask,
    input  logic [N_SROW-1:0]       srow_vld,
    input  logic [N_SROW*ROW_W-1:0] srow_addr,
    input  logic [N_SCG-1:0]        scg_vld,
    input  logic [N_SCG*SEG_W-1:0]  scg_seg,
    input  logic [N_SCG*COL_W-1:0]  scg_col,
    input  logic [N_SCG*SUB_W-1:0]  scg_sub,
    output logic                    row_hit,
    output logic                    col_share,
    output logic                    multi,
    output logic                    single,
    output logic [SUB_W-1:0]        single_idx
);
    logic [SEG_W-1:0] ev_seg;
    logic [NSW-1:0]   uncov;
    logic [N_SCG-1:0] place_hit;

    assign ev_seg = ev_row[ROW_W-1 -: SEG_W];

    always_comb begin
        row_hit = 1'b0;
        for (int i = 0; i < N_SROW; i++) begin
            if (srow_vld[i] && (srow_addr[i*ROW_W +: ROW_W] == ev_row))
                row_hit = 1'b1;
        end
    end

    always_comb begin
        for (int j = 0; j < N_SCG; j++) begin
            place_hit[j] = scg_vld[j]
                         && (scg_seg[j*SEG_W +: SEG_W] == ev_seg)
                         && (scg_col[j*COL_W +: COL_W] == ev_col);
        end
    end

    assign col_share = |place_hit;

    always_comb begin
        logic covered;
        for (int k = 0; k < NSW; k++) begin
            covered = 1'b0;
            for (int j = 0; j < N_SCG; j++) begin
                if (place_hit[j] && (scg_sub[j*SUB_W +: SUB_W] == SUB_W'(k)))
                    covered = 1'b1;
            end
            uncov[k] = ev_mask[k] & ~covered;
        end
    end

    always_comb begin
        int cnt;
        cnt        = 0;
        single_idx = '0;
        for (int k = NSW - 1; k >= 0; k--) begin
            if (uncov[k]) begin
                cnt        = cnt + 1;
                single_idx = SUB_W'(k);
            end
        end
        multi  = (cnt >= 2);
        single = (cnt == 1);
    end
endmodule

// File: rtl/subword_repair_alloc.sv
module subword_repair_alloc
    import sra_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 2,
    parameter int WORD_W = 16,
    parameter int GRP_W  = 4,
    parameter int N_SEG  = 2,
    parameter int N_SROW = 4,
    parameter int N_SCG  = 2,
    localparam int NSW   = WORD_W / GRP_W,
    localparam int SUB_W = (NSW > 1) ? $clog2(NSW) : 1,
    localparam int SEG_W = (N_SEG > 1) ? $clog2(N_SEG) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    test_end,
    input  logic                    fail_valid,
    input  logic [ROW_W-1:0]        fail_row,
    input  logic [COL_W-1:0]        fail_col,
    input  logic [NSW-1:0]          fail_mask,
    output logic                    ready,
    output logic                    done,
    output logic                    repairable,
    output logic [N_SROW-1:0]       srow_vld,
    output logic [N_SROW*ROW_W-1:0] srow_addr,
    output logic [N_SCG-1:0]        scg_vld,
    output logic [N_SCG*SEG_W-1:0]  scg_seg,
    output logic [N_SCG*COL_W-1:0]  scg_col,
    output logic [N_SCG*SUB_W-1:0]  scg_sub
);
    localparam int RIDX_W = (N_SROW > 1) ? $clog2(N_SROW) : 1;
    localparam int CIDX_W = (N_SCG > 1) ? $clog2(N_SCG) : 1;

    sra_state_e state_q, state_d;
    sra_act_e   act;

    logic [ROW_W-1:0]  ev_row_q;
    logic [COL_W-1:0]  ev_col_q;
    logic [NSW-1:0]    ev_mask_q;
    logic              repairable_q;

    logic [N_SROW-1:0] srow_vld_q;
    logic [ROW_W-1:0]  srow_addr_q [N_SROW];
    logic [N_SCG-1:0]  scg_vld_q;
    logic [SEG_W-1:0]  scg_seg_q [N_SCG];
    logic [COL_W-1:0]  scg_col_q [N_SCG];
    logic [SUB_W-1:0]  scg_sub_q [N_SCG];

    logic              row_hit, col_share, multi, single;
    logic [SUB_W-1:0]  single_idx;
    logic              row_free, col_free;
    logic [RIDX_W-1:0] row_idx;
    logic [CIDX_W-1:0] col_idx;

    genvar g;
    generate
        for (g = 0; g < N_SROW; g++) begin : g_srow_out
            assign srow_addr[g*ROW_W +: ROW_W] = srow_addr_q[g];
        end
        for (g = 0; g < N_SCG; g++) begin : g_scg_out
            assign scg_seg[g*SEG_W +: SEG_W] = scg_seg_q[g];
            assign scg_col[g*COL_W +: COL_W] = scg_col_q[g];
            assign scg_sub[g*SUB_W +: SUB_W] = scg_sub_q[g];
        end
    endgenerate

    assign srow_vld = srow_vld_q;
    assign scg_vld  = scg_vld_q;

    sra_cover_lookup #(
        .ROW_W (ROW_W), .COL_W (COL_W), .SEG_W (SEG_W), .NSW (NSW),
        .SUB_W (SUB_W), .N_SROW (N_SROW), .N_SCG (N_SCG)
    ) u_lookup (
        .ev_row     (ev_row_q),
        .ev_col     (ev_col_q),
        .ev_mask    (ev_mask_q),
        .srow_vld   (srow_vld),
        .srow_addr  (srow_addr),
        .scg_vld    (scg_vld),
        .scg_seg    (scg_seg),
        .scg_col    (scg_col),
        .scg_sub    (scg_sub),
        .row_hit    (row_hit),
        .col_share  (col_share),
        .multi      (multi),
        .single     (single),
        .single_idx (single_idx)
    );

    sra_free_pick #(.N (N_SROW), .IDX_W (RIDX_W)) u_row_pick (
        .vld (srow_vld_q), .found (row_free), .idx (row_idx)
    );

    sra_free_pick #(.N (N_SCG), .IDX_W (CIDX_W)) u_col_pick (
        .vld (scg_vld_q), .found (col_free), .idx (col_idx)
    );

    // Allocation decision, evaluated only in JUDGE
    always_comb begin
        act = ACT_NONE;
        if (state_q == ST_JUDGE && repairable_q && !row_hit) begin
            if (multi) begin
                act = row_free ? ACT_ROW : ACT_FAIL;
            end else if (single) begin
                if (col_share && row_free)
                    act = ACT_ROW;
                else
                    act = col_free ? ACT_COL : ACT_FAIL;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CLEAR;
            ST_CLEAR:   state_d = ST_COLLECT;
            ST_COLLECT: begin
                if (fail_valid)    state_d = ST_JUDGE;
                else if (test_end) state_d = ST_DONE;
            end
            ST_JUDGE:   state_d = ST_COLLECT;
            ST_DONE:    if (start) state_d = ST_CLEAR;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ready      = (state_q == ST_COLLECT);
        done       = (state_q == ST_DONE);
        repairable = repairable_q;
    end

    // Event capture and spare registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_row_q     <= '0;
            ev_col_q     <= '0;
            ev_mask_q    <= '0;
            repairable_q <= 1'b1;
            srow_vld_q   <= '0;
            scg_vld_q    <= '0;
            for (int i = 0; i < N_SROW; i++) srow_addr_q[i] <= '0;
            for (int j = 0; j < N_SCG; j++) begin
                scg_seg_q[j] <= '0;
                scg_col_q[j] <= '0;
                scg_sub_q[j] <= '0;
            end
        end else begin
            unique case (state_q)
                ST_CLEAR: begin
                    srow_vld_q   <= '0;
                    scg_vld_q    <= '0;
                    repairable_q <= 1'b1;
                end
                ST_COLLECT: begin
                    if (fail_valid) begin
                        ev_row_q  <= fail_row;
                        ev_col_q  <= fail_col;
                        ev_mask_q <= fail_mask;
                    end
                end
                ST_JUDGE: begin
                    unique case (act)
                        ACT_ROW: begin
                            srow_vld_q[row_idx]  <= 1'b1;
                            srow_addr_q[row_idx] <= ev_row_q;
                        end
                        ACT_COL: begin
                            scg_vld_q[col_idx] <= 1'b1;
                            scg_seg_q[col_idx] <= ev_row_q[ROW_W-1 -: SEG_W];
                            scg_col_q[col_idx] <= ev_col_q;
                            scg_sub_q[col_idx] <= single_idx;
                        end
                        ACT_FAIL: repairable_q <= 1'b0;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Assertions
    logic dup_row;
    always_comb begin
        dup_row = 1'b0;
        for (int a = 0; a < N_SROW; a++)
            for (int b = a + 1; b < N_SROW; b++)
                if (srow_vld_q[a] && srow_vld_q[b] && srow_addr_q[a] == srow_addr_q[b])
                    dup_row = 1'b1;
    end

    assert_no_dup_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_row);

    assert_clear_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((|($past(srow_vld_q) & ~srow_vld_q)) || (|($past(scg_vld_q) & ~scg_vld_q)))
        |-> $past(state_q) == ST_CLEAR);

    assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({srow_vld_q & ~$past(srow_vld_q), scg_vld_q & ~$past(scg_vld_q)}) <= 1);

    assert_grant_from_judge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(srow_vld_q & ~$past(srow_vld_q))) || (|(scg_vld_q & ~$past(scg_vld_q))))
        |-> $past(state_q) == ST_JUDGE);

    assert_sticky_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(repairable_q) |-> $past(state_q) == ST_CLEAR);

    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_valid && ready) |=> !ready);

endmodule

// File: tb/sim_subword_repair_alloc.sv
`timescale 1ns/1ps
module sim_subword_repair_alloc;
    localparam int ROW_W = 3, COL_W = 2, NSW = 4, SUB_W = 2, SEG_W = 1;
    localparam int N_SROW = 4, N_SCG = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, test_end = 1'b0, fail_valid = 1'b0;
    logic [ROW_W-1:0] fail_row = '0;
    logic [COL_W-1:0] fail_col = '0;
    logic [NSW-1:0]   fail_mask = '0;
    logic ready, done, repairable;
    logic [N_SROW-1:0]       srow_vld;
    logic [N_SROW*ROW_W-1:0] srow_addr;
    logic [N_SCG-1:0]        scg_vld;
    logic [N_SCG*SEG_W-1:0]  scg_seg;
    logic [N_SCG*COL_W-1:0]  scg_col;
    logic [N_SCG*SUB_W-1:0]  scg_sub;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    subword_repair_alloc u0 (
        .clk, .rst_n, .start, .test_end, .fail_valid, .fail_row, .fail_col,
        .fail_mask, .ready, .done, .repairable, .srow_vld, .srow_addr,
        .scg_vld, .scg_seg, .scg_col, .scg_sub
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input int r, input int c, input int m);
        @(negedge clk);
        while (!ready) @(negedge clk);
        fail_valid = 1'b1;
        fail_row   = ROW_W'(r);
        fail_col   = COL_W'(c);
        fail_mask  = NSW'(m);
        @(negedge clk);
        fail_valid = 1'b0;
        while (!ready) @(negedge clk);
    endtask

    task automatic do_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!ready) @(negedge clk);
    endtask

    task automatic chk_scg(input string req, input int j, input int s, input int c, input int k);
        chk(req, 32'(scg_seg[j*SEG_W +: SEG_W]), 32'(s));
        chk(req, 32'(scg_col[j*COL_W +: COL_W]), 32'(c));
        chk(req, 32'(scg_sub[j*SUB_W +: SUB_W]), 32'(k));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset srow_vld", 32'(srow_vld), 0);
        chk("R1 reset scg_vld", 32'(scg_vld), 0);
        chk("R1 reset repairable", 32'(repairable), 1);
        chk("R8 reset ready", 32'(ready), 0);
        chk("R9 reset done", 32'(done), 0);
    endtask

    task automatic t_first_run();
        do_start();
        chk("R8 ready in collect", 32'(ready), 1);
        send(1, 2, 4'b0001);
        chk("R5 single to column", 32'(scg_vld), 32'b01);
        chk_scg("R5 column entry", 0, 0, 2, 0);
        send(3, 2, 4'b0001);
        chk("R3 column covered", 32'(scg_vld), 32'b01);
        chk("R3 column covered rows", 32'(srow_vld), 0);
        send(6, 1, 4'b0000);
        chk("R3 zero mask", 32'({srow_vld, scg_vld}), 32'b000001);
        send(2, 1, 4'b0110);
        chk("R2 multi to row", 32'(srow_vld), 32'b0001);
        chk("R2 row address", 32'(srow_addr[0 +: ROW_W]), 2);
        send(2, 3, 4'b1000);
        chk("R3 row covered", 32'({srow_vld, scg_vld}), 32'b000101);
        send(0, 2, 4'b0100);
        chk("R4 shared column to row", 32'(srow_vld), 32'b0011);
        chk("R4 row address", 32'(srow_addr[ROW_W +: ROW_W]), 0);
        chk("R4 no column taken", 32'(scg_vld), 32'b01);
        send(5, 2, 4'b0001);
        chk("R7 other segment column", 32'(scg_vld), 32'b11);
        chk_scg("R7 segment one entry", 1, 1, 2, 0);
        send(6, 0, 4'b0010);
        chk("R6 columns exhausted", 32'(repairable), 0);
        send(3, 0, 4'b0001);
        chk("R6 sticky flag", 32'(repairable), 0);
        chk("R6 no allocation after fail", 32'({srow_vld, scg_vld}), 32'b001111);
        @(negedge clk);
        test_end = 1'b1;
        @(negedge clk);
        test_end = 1'b0;
        chk("R9 done", 32'(done), 1);
        chk("R9 not ready in done", 32'(ready), 0);
    endtask

    task automatic t_second_run();
        do_start();
        chk("R1 restart srow_vld", 32'(srow_vld), 0);
        chk("R1 restart scg_vld", 32'(scg_vld), 0);
        chk("R1 restart repairable", 32'(repairable), 1);
        chk("R9 done cleared", 32'(done), 0);
        send(1, 0, 4'b0001);
        for (int r = 4; r < 8; r++) send(r, 1, 4'b1100);
        chk("R2 rows filled", 32'(srow_vld), 32'b1111);
        chk("R2 last row address", 32'(srow_addr[3*ROW_W +: ROW_W]), 7);
        send(0, 0, 4'b0010);
        chk("R4 fallback to column", 32'(scg_vld), 32'b11);
        chk_scg("R4 fallback entry", 1, 0, 0, 1);
        chk("R4 still repairable", 32'(repairable), 1);
        send(3, 3, 4'b0011);
        chk("R6 rows exhausted", 32'(repairable), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_run();
        t_second_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule